// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer with Superpage Support

This block caches virtual-to-physical page translations for a memory system whose page tables are managed by software. A lookup presents a virtual address. The virtual page number is compared against every valid entry at once. On a hit the block returns the physical address, formed from the stored frame bits above the page offset and the untranslated offset bits of the request, together with the permission bits. On a miss it reports the miss and does no page-table walk. Software then writes the translation through the fill port and retries the access.

Each entry is tagged with an address-space identifier, so translations from several processes can stay resident at the same time. Each entry also carries a size code: a 4 KB base page, a 2 MB superpage or a 1 GB superpage. The size code decides how many low page-number bits the compare ignores. Software removes entries in one of two ways. A flush drops every entry, for example on a context switch when tags are not used. A targeted invalidate drops only the entries that match one page and one identifier, for example after a permission is reduced.

Lookups travel on a valid/ready request stream and a valid/ready response stream. The response is a single register. A request is accepted when `req_ready` is high, and `req_ready` is high whenever no response is pending or the pending response is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and new requests are stalled. The fill, invalidate and flush pins are plain one-cycle strobes with no handshake.

Top module: `tlbx_top`

## Requirements
- R1: A request accepted at a clock edge produces `rsp_valid` high in the following cycle. On a hit `rsp_hit` is 1, `rsp_perm` holds the stored permission bits, and for a 4 KB page `rsp_pa` is the stored frame number followed by request address bits 11:0.
- R2: When no entry matches, the response has `rsp_hit`=0, `rsp_fault`=0, `rsp_multi`=0 and `rsp_pa`=0.
- R3: An entry matches only when its identifier equals `cur_asid`. The same page under another identifier misses.
- R4: Size code 0 is 4 KB, 1 is 2 MB and 2 is 1 GB. Code 3 is stored and treated as 4 KB. For a superpage, the compare ignores the low 9 (2 MB) or 18 (1 GB) page-number bits, and `rsp_pa` takes request address bits 20:0 or 29:0 with the frame bits above them.
- R5: `flush` clears every entry. A fill or invalidate in the same cycle as a flush is discarded.
- R6: An invalidate clears the entries whose page and identifier match `inv_vpn` and `inv_asid`, using each entry's own size. All other entries, including the same page under another identifier, survive.
- R7: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access code 0 is read, 1 is write, 2 is execute and 3 is read. A hit whose required bit is clear has `rsp_fault`=1, with `rsp_hit` still 1.
- R8: A fill goes to the lowest-index invalid entry. When every entry is valid, it goes to a round-robin pointer. The pointer resets to 0, advances (wrapping at DEPTH, default 16) only when it is used, and is not moved by a flush.
- R9: A fill whose page, identifier and normalized size match a valid entry overwrites that entry and creates no duplicate.
- R10: If several entries match a lookup, the lowest-index entry supplies the result and `rsp_multi` is 1.
- R11: `req_ready` equals not `rsp_valid` or `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response field holds.
- R12: A fill or invalidate in the same cycle as an accepted lookup does not affect that lookup. It applies from the next cycle on.
- R13: After reset no entry is valid, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_asid | input | 8 | Current address-space identifier |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready |
| req_va | input | 48 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Hit, but the access kind is not permitted |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pa | output | 44 | Physical address (0 on a miss) |
| rsp_perm | output | 3 | Stored permissions {exec, write, read} |
| fill_en | input | 1 | Write one translation |
| fill_vpn | input | 36 | Virtual page number to write |
| fill_asid | input | 8 | Identifier of the written entry |
| fill_size | input | 2 | Page size code of the written entry |
| fill_pfn | input | 32 | Frame number of the written entry |
| fill_perm | input | 3 | Permissions of the written entry |
| inv_en | input | 1 | Invalidate matching entries |
| inv_vpn | input | 36 | Page to invalidate |
| inv_asid | input | 8 | Identifier to invalidate |
| flush | input | 1 | Clear all entries |

## Verification
The assertions assume that every input is at a known level from reset release onward, and that `flush`, `fill_en` and `inv_en` stay low during reset. They do not assume that software avoids overlapping entries: the multiple-match property only requires `rsp_multi` to come with a hit. The bench drives every input on the falling clock edge and holds the strobes low while reset is asserted. It builds the one overlapping pair (a 2 MB page and a 4 KB page inside it) on purpose, to exercise the priority rule.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W   = 48;
  localparam int PA_W   = 44;
  localparam int ASID_W = 8;
  localparam int PERM_W = 3;
  localparam int OFS_W  = 12;
  localparam int MID_W  = 9;   // extra offset bits of a 2 MB page
  localparam int BIG_W  = 18;  // extra offset bits of a 1 GB page
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int PFN_W  = PA_W - OFS_W;

  localparam logic [1:0] SZ_4K = 2'd0;
  localparam logic [1:0] SZ_2M = 2'd1;
  localparam logic [1:0] SZ_1G = 2'd2;

  typedef struct packed {
    logic              valid;
    logic [ASID_W-1:0] asid;
    logic [1:0]        size;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;

  // page-number bits that take part in the compare
  function automatic logic [VPN_W-1:0] page_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    if (sz == SZ_2M) m[MID_W-1:0] = '0;
    if (sz == SZ_1G) m[BIG_W-1:0] = '0;
    return m;
  endfunction

  // physical address bits passed through from the request
  function automatic logic [PA_W-1:0] ofs_mask(input logic [1:0] sz);
    logic [PA_W-1:0] m;
    m = '0;
    m[OFS_W-1:0] = '1;
    if (sz == SZ_2M) m[OFS_W+MID_W-1:0] = '1;
    if (sz == SZ_1G) m[OFS_W+BIG_W-1:0] = '1;
    return m;
  endfunction
endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  tlb_ent_t          ents [DEPTH],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  input  logic              size_chk,
  input  logic [1:0]        size,
  output logic [DEPTH-1:0]  hits
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hits[g] = ents[g].valid && (ents[g].asid == asid) &&
                     (((ents[g].vpn ^ vpn) & page_mask(ents[g].size)) == '0) &&
                     (!size_chk || (ents[g].size == size));
  end
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick #(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0]                               vec,
  output logic                                           any,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0]   idx
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // lowest set index wins
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              rsp_multi,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [1:0]        fill_size,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              flush
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tlb_ent_t         ents [DEPTH];
  logic [IDX_W-1:0] rr;

  logic [DEPTH-1:0] lk_hits, inv_hits, dup_hits, free_vec;
  logic             lk_any, dup_any, free_any, lk_multi;
  logic [IDX_W-1:0] lk_idx, dup_idx, free_idx, fill_slot;
  logic [VPN_W-1:0] req_vpn;
  logic [1:0]       fill_sz_n;
  logic [PA_W-1:0]  omask, lk_pa;
  logic             perm_ok, accept;
  tlb_ent_t         new_ent;

  assign req_vpn   = req_va[VA_W-1:OFS_W];
  assign fill_sz_n = (fill_size == 2'd3) ? SZ_4K : fill_size;

  for (genvar g = 0; g < DEPTH; g++) begin : g_free
    assign free_vec[g] = !ents[g].valid;
  end

  tlbx_match #(.DEPTH(DEPTH)) u_lk_cmp (
    .ents(ents), .vpn(req_vpn), .asid(cur_asid),
    .size_chk(1'b0), .size(SZ_4K), .hits(lk_hits));
  tlbx_match #(.DEPTH(DEPTH)) u_inv_cmp (
    .ents(ents), .vpn(inv_vpn), .asid(inv_asid),
    .size_chk(1'b0), .size(SZ_4K), .hits(inv_hits));
  tlbx_match #(.DEPTH(DEPTH)) u_dup_cmp (
    .ents(ents), .vpn(fill_vpn), .asid(fill_asid),
    .size_chk(1'b1), .size(fill_sz_n), .hits(dup_hits));

  tlbx_pick #(.DEPTH(DEPTH)) u_lk_pick   (.vec(lk_hits),  .any(lk_any),   .idx(lk_idx));
  tlbx_pick #(.DEPTH(DEPTH)) u_dup_pick  (.vec(dup_hits), .any(dup_any),  .idx(dup_idx));
  tlbx_pick #(.DEPTH(DEPTH)) u_free_pick (.vec(free_vec), .any(free_any), .idx(free_idx));

  assign lk_multi = (lk_hits & (lk_hits - 1'b1)) != '0;

  // physical address: frame bits above the page offset, request bits below
  assign omask = ofs_mask(ents[lk_idx].size);
  assign lk_pa = ({ents[lk_idx].pfn, {OFS_W{1'b0}}} & ~omask) |
                 (req_va[PA_W-1:0] & omask);

  always_comb begin
    case (req_acc)
      2'd1:    perm_ok = ents[lk_idx].perm[1];
      2'd2:    perm_ok = ents[lk_idx].perm[2];
      default: perm_ok = ents[lk_idx].perm[0];
    endcase
  end

  assign fill_slot = dup_any ? dup_idx : (free_any ? free_idx : rr);
  assign new_ent   = '{valid: 1'b1, asid: fill_asid, size: fill_sz_n,
                       vpn: fill_vpn, pfn: fill_pfn, perm: fill_perm};

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  // entry store: flush beats invalidate, fill is applied last
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
      rr <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) ents[i].valid <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (inv_en && inv_hits[i]) ents[i].valid <= 1'b0;
      end
      if (fill_en) begin
        ents[fill_slot] <= new_ent;
        if (!dup_any && !free_any)
          rr <= (rr == IDX_W'(DEPTH - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_perm  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= lk_any;
      rsp_fault <= lk_any && !perm_ok;
      rsp_multi <= lk_multi;
      rsp_pa    <= lk_any ? lk_pa : '0;
      rsp_perm  <= lk_any ? ents[lk_idx].perm : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk
  import tlbx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic            rsp_multi,
  input logic [PA_W-1:0] rsp_pa,
  input logic            flush
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_clean_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_fault && !rsp_multi && rsp_pa == '0));

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && req_valid && req_ready) |=> (rsp_valid && !rsp_hit));

  assert_fault_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_hit);

  assert_multi_on_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi) |-> rsp_hit);

  assert_hold_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
      $stable(rsp_fault) && $stable(rsp_multi) && $stable(rsp_pa)));
endmodule

bind tlbx_top tlbx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_multi(rsp_multi), .rsp_pa(rsp_pa), .flush(flush)
);

// File: tb/sim_tlbx_top.sv
module sim_tlbx_top;
  import tlbx_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ASID_W-1:0] cur_asid;
  logic              req_valid, req_ready;
  logic [VA_W-1:0]   req_va;
  logic [1:0]        req_acc;
  logic              rsp_valid, rsp_ready, rsp_hit, rsp_fault, rsp_multi;
  logic [PA_W-1:0]   rsp_pa;
  logic [PERM_W-1:0] rsp_perm;
  logic              fill_en;
  logic [VPN_W-1:0]  fill_vpn;
  logic [ASID_W-1:0] fill_asid;
  logic [1:0]        fill_size;
  logic [PFN_W-1:0]  fill_pfn;
  logic [PERM_W-1:0] fill_perm;
  logic              inv_en;
  logic [VPN_W-1:0]  inv_vpn;
  logic [ASID_W-1:0] inv_asid;
  logic              flush;

  int total = 0;
  int bad = 0;
  logic g_hit, g_fault, g_multi;
  logic [PA_W-1:0] g_pa;
  logic [PERM_W-1:0] g_perm;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlbx_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] exp_pa(input logic [PFN_W-1:0] pfn, input logic [VA_W-1:0] va,
                                             input logic [1:0] sz);
    case (sz)
      2'd1:    return {pfn[31:9], va[20:0]};
      2'd2:    return {pfn[31:18], va[29:0]};
      default: return {pfn, va[11:0]};
    endcase
  endfunction

  task automatic lookup(input logic [VA_W-1:0] va, input logic [1:0] acc);
    @(negedge clk);
    req_va = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    g_hit = rsp_hit; g_fault = rsp_fault; g_multi = rsp_multi; g_pa = rsp_pa; g_perm = rsp_perm;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid, input logic [1:0] sz,
                      input logic [PFN_W-1:0] pfn, input logic [PERM_W-1:0] perm);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_size = sz; fill_pfn = pfn; fill_perm = perm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic inval(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid);
    @(negedge clk);
    inv_en = 1'b1; inv_vpn = vpn; inv_asid = asid;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    chk(rsp_valid == 1'b0, "R13 rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R13 req_ready after reset", req_ready, 1);
    lookup({36'h0, 12'h000}, 2'd0);
    chk(g_hit == 1'b0, "R13 empty after reset", g_hit, 0);
  endtask

  task automatic t_basic();
    do_flush();
    fill(36'h0_0000_1234, 8'd1, 2'd0, 32'h0005_6789, 3'b111);
    @(negedge clk); req_va = {36'h0_0000_1234, 12'h345}; req_acc = 2'd0; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R1 rsp_valid one cycle later", rsp_valid, 1);
    chk(rsp_hit == 1'b1, "R1 hit", rsp_hit, 1);
    chk(rsp_pa == {32'h0005_6789, 12'h345}, "R1 pa", rsp_pa, {32'h0005_6789, 12'h345});
    chk(rsp_perm == 3'b111, "R1 perm", rsp_perm, 3'b111);
    lookup({36'h0_0000_1235, 12'h345}, 2'd0);
    chk(g_hit == 1'b0 && g_fault == 1'b0 && g_multi == 1'b0, "R2 miss flags", {g_hit, g_fault, g_multi}, 0);
    chk(g_pa == '0, "R2 miss pa zero", g_pa, 0);
  endtask

  task automatic t_asid();
    do_flush();
    fill(36'h0_0000_0777, 8'd1, 2'd0, 32'h0000_0AAA, 3'b001);
    cur_asid = 8'd2;
    lookup({36'h0_0000_0777, 12'h010}, 2'd0);
    chk(g_hit == 1'b0, "R3 other asid misses", g_hit, 0);
    cur_asid = 8'd1;
    lookup({36'h0_0000_0777, 12'h010}, 2'd0);
    chk(g_hit == 1'b1, "R3 own asid hits", g_hit, 1);
  endtask

  task automatic t_sizes();
    logic [VA_W-1:0] va;
    do_flush();
    fill(36'h0_0012_3400, 8'd1, 2'd1, 32'hABCD_E000, 3'b001);
    va = {36'h0_0012_34AB, 12'h567};
    lookup(va, 2'd0);
    chk(g_hit == 1'b1, "R4 2MB hit", g_hit, 1);
    chk(g_pa == exp_pa(32'hABCD_E000, va, 2'd1), "R4 2MB pa", g_pa, exp_pa(32'hABCD_E000, va, 2'd1));
    fill(36'h0_0C00_0000, 8'd1, 2'd2, 32'h1234_5000, 3'b001);
    va = {36'h0_0C02_3456, 12'h9AB};
    lookup(va, 2'd0);
    chk(g_hit == 1'b1, "R4 1GB hit", g_hit, 1);
    chk(g_pa == exp_pa(32'h1234_5000, va, 2'd2), "R4 1GB pa", g_pa, exp_pa(32'h1234_5000, va, 2'd2));
    lookup({36'h0_0C04_0000, 12'h000}, 2'd0);
    chk(g_hit == 1'b0, "R4 beyond 1GB misses", g_hit, 0);
    fill(36'h0_0000_0900, 8'd1, 2'd3, 32'h0000_0777, 3'b001);
    lookup({36'h0_0000_0901, 12'h000}, 2'd0);
    chk(g_hit == 1'b0, "R4 code 3 is 4KB (neighbour misses)", g_hit, 0);
    va = {36'h0_0000_0900, 12'hFED};
    lookup(va, 2'd0);
    chk(g_hit == 1'b1 && g_pa == exp_pa(32'h0000_0777, va, 2'd0), "R4 code 3 hit", g_pa,
        exp_pa(32'h0000_0777, va, 2'd0));
  endtask

  task automatic t_perm();
    do_flush();
    fill(36'h0_0000_0050, 8'd1, 2'd0, 32'h0000_0050, 3'b001);
    lookup({36'h0_0000_0050, 12'h0}, 2'd0);
    chk(g_hit == 1'b1 && g_fault == 1'b0, "R7 read allowed", {g_hit, g_fault}, 2'b10);
    lookup({36'h0_0000_0050, 12'h0}, 2'd1);
    chk(g_hit == 1'b1 && g_fault == 1'b1, "R7 write faults", {g_hit, g_fault}, 2'b11);
    lookup({36'h0_0000_0050, 12'h0}, 2'd2);
    chk(g_fault == 1'b1, "R7 exec faults", g_fault, 1);
    lookup({36'h0_0000_0050, 12'h0}, 2'd3);
    chk(g_fault == 1'b0, "R7 code 3 is read", g_fault, 0);
  endtask

  task automatic t_inval();
    do_flush();
    fill(36'h0_0000_0A00, 8'd1, 2'd0, 32'h0000_0111, 3'b001);
    fill(36'h0_0000_0B00, 8'd1, 2'd0, 32'h0000_0222, 3'b001);
    inval(36'h0_0000_0A00, 8'd2);
    lookup({36'h0_0000_0A00, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R6 other asid invalidate ignored", g_hit, 1);
    inval(36'h0_0000_0A00, 8'd1);
    lookup({36'h0_0000_0A00, 12'h0}, 2'd0);
    chk(g_hit == 1'b0, "R6 target cleared", g_hit, 0);
    lookup({36'h0_0000_0B00, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R6 neighbour survives", g_hit, 1);
  endtask

  task automatic t_flush();
    do_flush();
    fill(36'h0_0000_0C00, 8'd1, 2'd0, 32'h0000_0333, 3'b001);
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 36'h0_0000_0D00; fill_asid = 8'd1;
    fill_size = 2'd0; fill_pfn = 32'h0000_0444; fill_perm = 3'b001;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    lookup({36'h0_0000_0C00, 12'h0}, 2'd0);
    chk(g_hit == 1'b0, "R5 old entry flushed", g_hit, 0);
    lookup({36'h0_0000_0D00, 12'h0}, 2'd0);
    chk(g_hit == 1'b0, "R5 same-cycle fill discarded", g_hit, 0);
  endtask

  task automatic t_dup();
    do_flush();
    fill(36'h0_0000_0E00, 8'd1, 2'd0, 32'h0000_1111, 3'b001);
    fill(36'h0_0000_0E00, 8'd1, 2'd0, 32'h0000_2222, 3'b011);
    lookup({36'h0_0000_0E00, 12'h004}, 2'd0);
    chk(g_multi == 1'b0, "R9 no duplicate", g_multi, 0);
    chk(g_pa == {32'h0000_2222, 12'h004}, "R9 overwritten frame", g_pa, {32'h0000_2222, 12'h004});
    chk(g_perm == 3'b011, "R9 overwritten perm", g_perm, 3'b011);
  endtask

  task automatic t_multi();
    logic [VA_W-1:0] va;
    do_flush();
    fill(36'h0_0012_3400, 8'd1, 2'd1, 32'hABCD_E000, 3'b001);
    fill(36'h0_0012_34AB, 8'd1, 2'd0, 32'h0000_0999, 3'b001);
    va = {36'h0_0012_34AB, 12'h111};
    lookup(va, 2'd0);
    chk(g_multi == 1'b1, "R10 multi flag", g_multi, 1);
    chk(g_pa == exp_pa(32'hABCD_E000, va, 2'd1), "R10 lowest index wins", g_pa,
        exp_pa(32'hABCD_E000, va, 2'd1));
    lookup({36'h0_0012_3401, 12'h0}, 2'd0);
    chk(g_hit == 1'b1 && g_multi == 1'b0, "R10 single match no flag", {g_hit, g_multi}, 2'b10);
  endtask

  task automatic t_rr();
    do_flush();
    for (int i = 0; i < 16; i++) fill(36'h100 + 36'(i), 8'd1, 2'd0, 32'h500 + 32'(i), 3'b001);
    lookup({36'h10F, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R8 all sixteen resident", g_hit, 1);
    fill(36'h110, 8'd1, 2'd0, 32'h510, 3'b001);
    lookup({36'h100, 12'h0}, 2'd0);
    chk(g_hit == 1'b0, "R8 first victim is entry 0", g_hit, 0);
    lookup({36'h101, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R8 entry 1 kept", g_hit, 1);
    fill(36'h111, 8'd1, 2'd0, 32'h511, 3'b001);
    lookup({36'h101, 12'h0}, 2'd0);
    chk(g_hit == 1'b0, "R8 second victim is entry 1", g_hit, 0);
    inval(36'h105, 8'd1);
    fill(36'h112, 8'd1, 2'd0, 32'h512, 3'b001);
    lookup({36'h102, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R8 free slot used before pointer", g_hit, 1);
    lookup({36'h112, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R8 refill resident", g_hit, 1);
    fill(36'h113, 8'd1, 2'd0, 32'h513, 3'b001);
    lookup({36'h102, 12'h0}, 2'd0);
    chk(g_hit == 1'b0, "R8 pointer resumes at entry 2", g_hit, 0);
    lookup({36'h103, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R8 entry 3 kept", g_hit, 1);
  endtask

  task automatic t_same_cycle();
    do_flush();
    @(negedge clk);
    req_va = {36'h0_0000_0F00, 12'h0}; req_acc = 2'd0; req_valid = 1'b1;
    fill_en = 1'b1; fill_vpn = 36'h0_0000_0F00; fill_asid = 8'd1; fill_size = 2'd0;
    fill_pfn = 32'h0000_0F0F; fill_perm = 3'b001;
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    chk(rsp_hit == 1'b0, "R12 fill not seen by same-cycle lookup", rsp_hit, 0);
    lookup({36'h0_0000_0F00, 12'h0}, 2'd0);
    chk(g_hit == 1'b1, "R12 fill seen next cycle", g_hit, 1);
    @(negedge clk);
    req_va = {36'h0_0000_0F00, 12'h0}; req_valid = 1'b1;
    inv_en = 1'b1; inv_vpn = 36'h0_0000_0F00; inv_asid = 8'd1;
    @(negedge clk);
    req_valid = 1'b0; inv_en = 1'b0;
    chk(rsp_hit == 1'b1, "R12 invalidate not seen by same-cycle lookup", rsp_hit, 1);
    lookup({36'h0_0000_0F00, 12'h0}, 2'd0);
    chk(g_hit == 1'b0, "R12 invalidate seen next cycle", g_hit, 0);
  endtask

  task automatic t_stream();
    do_flush();
    fill(36'h0_0000_0123, 8'd1, 2'd0, 32'h0000_0456, 3'b001);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_va = {36'h0_0000_0123, 12'h078}; req_acc = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_va = {36'h0_0000_0999, 12'h0};
    chk(req_ready == 1'b0, "R11 stalled while response pending", req_ready, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b1, "R11 response held", {rsp_valid, rsp_hit}, 2'b11);
    chk(rsp_pa == {32'h0000_0456, 12'h078}, "R11 pa held", rsp_pa, {32'h0000_0456, 12'h078});
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R11 ready when response taken", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b0, "R11 second response", {rsp_valid, rsp_hit}, 2'b10);
  endtask

  initial begin
    rst_n = 1'b0; cur_asid = 8'd1; req_valid = 1'b0; req_va = '0; req_acc = 2'd0;
    rsp_ready = 1'b1; fill_en = 1'b0; fill_vpn = '0; fill_asid = '0; fill_size = '0;
    fill_pfn = '0; fill_perm = '0; inv_en = 1'b0; inv_vpn = '0; inv_asid = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_asid();
    t_sizes();
    t_perm();
    t_inval();
    t_flush();
    t_dup();
    t_multi();
    t_rr();
    t_same_cycle();
    t_stream();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule